// File: doc/BRIEF.md
# Vectored Pin Interrupt Controller

This block is the interrupt front end of a small microcontroller. It watches a few external interrupt pins and three groups of eight pin-change inputs. It keeps a flag for every edge-mode pin and for every pin-change group, combines the flags with per-source enables and a global enable, and picks one winner. It then raises a request to the core, together with the program-memory vector address of the winning source. Address zero is reserved for the reset vector. Each source has its own fixed entry above it, and a lower address means a higher priority.

The core reports every retired instruction and, separately, every retired return-from-interrupt. The controller only takes an interrupt at an instruction boundary. Acceptance clears the global enable. A return-from-interrupt sets it again, but no interrupt is taken on that same boundary, so one more instruction of the interrupted program always runs first. Software reaches the mode, mask, enable and flag registers through a simple byte-wide register port. Flags are cleared by writing ones to them.

Top module: `pcint_irq_unit`

## Requirements
- R1: After reset, every register (addresses 0 to 8) reads zero and `irq_req_o` is low.
- R2: Address 1 holds a two-bit mode per external pin k, at bits 2k+1:2k. The codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. In an edge mode, flag bit k (address 3) sets when the synchronised pin shows the selected edge, whatever the mask says.
- R3: Writing a one to a flag bit at address 3 or address 5 clears that bit, and writing a zero leaves it unchanged.
- R4: In low-level mode, flag bit k always reads zero. The pin raises a request for as long as it is low and its mask bit (address 2, bit k) is set, and an acknowledge does not stop it.
- R5: Group flag g (address 5, bit g) sets when any pin 8g+i toggles while bit i of that group's pin mask (address 6+g) is set. A toggle on a pin whose mask bit is clear leaves the flag unchanged.
- R6: An edge-mode pin requests only when both its flag and its mask bit are set. A group requests only when both its flag and its enable bit (address 4, bit g) are set.
- R7: A request is accepted only in a cycle where `retire_i` is high, the global enable (address 0, bit 0) is set and no request is outstanding. `irq_req_o` rises in the next cycle and the global enable reads zero.
- R8: The lowest vector wins. With the default parameters, external pin k has vector 2(k+1) and group g has vector 2(3+g), giving 2, 4, 6, 8 and 10. The vector stays stable while the request is high.
- R9: With `irq_ack_i` high while a request is outstanding, `irq_req_o` falls in the next cycle. The flag of the accepted edge-mode or group source is cleared at the same time.
- R10: Asserting `reti_i` together with `retire_i` sets the global enable, and no request is accepted on that boundary. The next retired instruction without `reti_i` may be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | External interrupt pins (asynchronous) |
| pc_pin_i | input | 24 | Pin-change inputs; pin 8g+i belongs to group g |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| retire_i | input | 1 | Core retired an instruction this cycle |
| reti_i | input | 1 | The retired instruction is a return-from-interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector address of the accepted source |
| irq_ack_i | input | 1 | Core acknowledges the request |

## Verification
The bench drives the cycle right after a return-from-interrupt. A design that takes a pending request at the return's own boundary would show a request one instruction too early. Several sources are made to pend together, so a priority encoder that favoured the highest index would return the wrong vector. The bench also checks that an acknowledge clears only the flag of the winning source, and that a level-mode source keeps requesting after its acknowledge. Random pin-change toggles under random masks catch a design that ignores the pin mask or sets the wrong group flag, and writes of zero to the flag registers catch a clear that acts on plain writes.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_ANY   = 2'b01,
        MODE_FALL  = 2'b10,
        MODE_RISE  = 2'b11
    } ext_mode_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_EMODE  = 1;
    localparam int ADDR_EMASK  = 2;
    localparam int ADDR_EFLAG  = 3;
    localparam int ADDR_GEN    = 4;
    localparam int ADDR_GFLAG  = 5;
    localparam int ADDR_GMASK0 = 6;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign sync_o = stab_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N  = 5,
    parameter int SW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [SW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // scan downward so the lowest set index is the one left standing
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = SW'(i);
        end
    end
endmodule

// File: rtl/pcint_irq_unit.sv
module pcint_irq_unit
    import irq_pkg::*;
#(
    parameter int NEXT    = 2,
    parameter int NGRP    = 3,
    parameter int GW      = 8,
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int VAW     = 8,
    parameter int VSTRIDE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NEXT-1:0]      ext_pin_i,
    input  logic [NGRP*GW-1:0]   pc_pin_i,
    input  logic                 reg_we_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [DW-1:0]        reg_wdata_i,
    output logic [DW-1:0]        reg_rdata_o,
    input  logic                 retire_i,
    input  logic                 reti_i,
    output logic                 irq_req_o,
    output logic [VAW-1:0]       irq_vec_o,
    input  logic                 irq_ack_i
);
    localparam int NSRC = NEXT + NGRP;
    localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int NPC  = NGRP * GW;

    typedef struct packed {
        logic                      gie;
        logic [NEXT-1:0][1:0]      mode;
        logic [NEXT-1:0]           emask;
        logic [NEXT-1:0]           eflag;
        logic [NGRP-1:0]           gen;
        logic [NGRP-1:0]           gflag;
        logic [NGRP-1:0][GW-1:0]   gmask;
        logic                      req;
        logic [SW-1:0]             sel;
    } state_t;

    state_t s_d, s_q;

    logic [NEXT-1:0] ext_sync, ext_prev;
    logic [NPC-1:0]  pc_sync, pc_prev;
    logic [NEXT-1:0] ext_hit, ext_req;
    logic [NGRP-1:0] grp_hit, grp_req;
    logic [NSRC-1:0] src_req;
    logic            win_any;
    logic [SW-1:0]   win_idx;
    logic            accept;

    irq_sync #(.W(NEXT)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
        .sync_o(ext_sync), .prev_o(ext_prev)
    );

    irq_sync #(.W(NPC)) u_pc_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pc_pin_i),
        .sync_o(pc_sync), .prev_o(pc_prev)
    );

    irq_prio #(.N(NSRC), .SW(SW)) u_prio (
        .req_i(src_req), .any_o(win_any), .idx_o(win_idx)
    );

    // source detection and request formation
    always_comb begin
        for (int k = 0; k < NEXT; k++) begin
            case (ext_mode_e'(s_q.mode[k]))
                MODE_ANY:  ext_hit[k] = ext_sync[k] ^ ext_prev[k];
                MODE_FALL: ext_hit[k] = ext_prev[k] & ~ext_sync[k];
                MODE_RISE: ext_hit[k] = ~ext_prev[k] & ext_sync[k];
                default:   ext_hit[k] = 1'b0;
            endcase
            if (ext_mode_e'(s_q.mode[k]) == MODE_LEVEL)
                ext_req[k] = ~ext_sync[k] & s_q.emask[k];
            else
                ext_req[k] = s_q.eflag[k] & s_q.emask[k];
        end
        for (int g = 0; g < NGRP; g++) begin
            grp_hit[g] = |((pc_sync[g*GW +: GW] ^ pc_prev[g*GW +: GW]) & s_q.gmask[g]);
        end
        grp_req = s_q.gflag & s_q.gen;
        src_req = {grp_req, ext_req};
        accept  = retire_i && !reti_i && s_q.gie && !s_q.req && win_any;
    end

    // next-state
    always_comb begin
        s_d = s_q;

        if (reg_we_i) begin
            case (reg_addr_i)
                AW'(ADDR_CTRL):  s_d.gie   = reg_wdata_i[0];
                AW'(ADDR_EMODE): s_d.mode  = reg_wdata_i[2*NEXT-1:0];
                AW'(ADDR_EMASK): s_d.emask = reg_wdata_i[NEXT-1:0];
                AW'(ADDR_EFLAG): s_d.eflag = s_q.eflag & ~reg_wdata_i[NEXT-1:0];
                AW'(ADDR_GEN):   s_d.gen   = reg_wdata_i[NGRP-1:0];
                AW'(ADDR_GFLAG): s_d.gflag = s_q.gflag & ~reg_wdata_i[NGRP-1:0];
                default: begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (reg_addr_i == AW'(ADDR_GMASK0 + g))
                            s_d.gmask[g] = reg_wdata_i[GW-1:0];
                    end
                end
            endcase
        end

        if (s_q.req && irq_ack_i) begin
            s_d.req = 1'b0;
            for (int k = 0; k < NEXT; k++)
                if (s_q.sel == SW'(k)) s_d.eflag[k] = 1'b0;
            for (int g = 0; g < NGRP; g++)
                if (s_q.sel == SW'(NEXT + g)) s_d.gflag[g] = 1'b0;
        end

        // new events win over any clear in the same cycle
        s_d.eflag = s_d.eflag | ext_hit;
        s_d.gflag = s_d.gflag | grp_hit;
        for (int k = 0; k < NEXT; k++)
            if (ext_mode_e'(s_d.mode[k]) == MODE_LEVEL) s_d.eflag[k] = 1'b0;

        if (retire_i && reti_i) s_d.gie = 1'b1;

        if (accept) begin
            s_d.req = 1'b1;
            s_d.sel = win_idx;
            s_d.gie = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // register read
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            AW'(ADDR_CTRL):  reg_rdata_o = DW'(s_q.gie);
            AW'(ADDR_EMODE): reg_rdata_o = DW'(s_q.mode);
            AW'(ADDR_EMASK): reg_rdata_o = DW'(s_q.emask);
            AW'(ADDR_EFLAG): reg_rdata_o = DW'(s_q.eflag);
            AW'(ADDR_GEN):   reg_rdata_o = DW'(s_q.gen);
            AW'(ADDR_GFLAG): reg_rdata_o = DW'(s_q.gflag);
            default: begin
                for (int g = 0; g < NGRP; g++)
                    if (reg_addr_i == AW'(ADDR_GMASK0 + g))
                        reg_rdata_o = DW'(s_q.gmask[g]);
            end
        endcase
    end

    assign irq_req_o = s_q.req;
    assign irq_vec_o = VAW'((32'(s_q.sel) + 1) * VSTRIDE);

    // ---------------- assertions ----------------
    assert_accept_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> !s_q.gie);

    assert_accept_on_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> $past(retire_i));

    assert_no_accept_at_reti_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && reti_i) |=> !$rose(irq_req_o));

    assert_ack_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i) |=> !irq_req_o);

    assert_vec_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && $past(irq_req_o)) |-> $stable(irq_vec_o));

    assert_winner_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> (32'(win_idx) < NSRC));

    for (genvar k = 0; k < NEXT; k++) begin : g_lvl_chk
        assert_level_flag_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr_i == AW'(ADDR_EFLAG) && ext_mode_e'(s_q.mode[k]) == MODE_LEVEL)
                |-> !reg_rdata_o[k]);
    end

endmodule

// File: tb/pcint_irq_unit_test.sv
module pcint_irq_unit_test;
    localparam int NEXT = 2, NGRP = 3, GW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin = '0;
    logic [23:0] pc_pin = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        retire = 1'b0, reti = 1'b0, ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pcint_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .pc_pin_i(pc_pin),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .retire_i(retire), .reti_i(reti),
        .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_ack_i(ack)
    );

    function automatic int vec_of(int idx);
        return 2 * (idx + 1);
    endfunction

    function automatic int lowest_grp(logic [2:0] m);
        for (int g = 0; g < NGRP; g++) if (m[g]) return g;
        return -1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic retire_one(bit is_reti);
        retire = 1'b1; reti = is_reti;
        @(negedge clk);
        retire = 1'b0; reti = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        void'($urandom(32'd4711));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        for (int a = 0; a <= 8; a++) begin
            rd(a, v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset request", int'(irq_req), 0);

        // R2 edge modes: ext0 rising (11), ext1 falling (10)
        wr(1, 8'b1011);
        ext_pin = 2'b01; step(4);
        rd(3, v); check("R2 rising edge sets flag", v, 1);
        ext_pin = 2'b11; step(4);
        rd(3, v); check("R2 rising ignored in falling mode", v, 1);
        ext_pin = 2'b01; step(4);
        rd(3, v); check("R2 falling edge sets flag", v, 3);

        // R3 write-one-to-clear
        wr(3, 0);
        rd(3, v); check("R3 write zero keeps flags", v, 3);
        wr(3, 1);
        rd(3, v); check("R3 write one clears bit0", v, 2);
        wr(3, 2);
        rd(3, v); check("R3 write one clears bit1", v, 0);

        // R2 any-change mode on ext0, falling direction
        wr(1, 8'b1001);
        ext_pin = 2'b00; step(4);
        rd(3, v); check("R2 any change sets flag", v, 1);
        wr(3, 3);

        // R4 level mode on ext1 (pin low)
        wr(1, 8'b0001);
        rd(3, v); check("R4 level flag reads zero", v & 2, 0);
        wr(2, 2);
        wr(0, 1);
        step(3);
        check("R7 no accept without retire", int'(irq_req), 0);
        retire_one(0);
        check("R7 request after retire", int'(irq_req), 1);
        check("R8 level ext1 vector", int'(irq_vec), vec_of(1));
        rd(0, v); check("R7 accept clears global enable", v, 0);
        do_ack();
        check("R9 ack drops request", int'(irq_req), 0);
        wr(0, 1);
        retire_one(0);
        check("R4 level source persists after ack", int'(irq_req), 1);
        do_ack();
        ext_pin = 2'b10; step(4);
        wr(0, 1);
        retire_one(0);
        check("R4 level high gives no request", int'(irq_req), 0);
        wr(2, 0); wr(0, 0); wr(3, 3);

        // R5 pin-change masking
        wr(6, 8'h01);
        pc_pin[1] = 1'b1; step(4);
        rd(5, v); check("R5 unmasked toggle ignored", v, 0);
        pc_pin[0] = 1'b1; step(4);
        rd(5, v); check("R5 masked toggle sets group0", v, 1);
        wr(8, 8'h80);
        pc_pin[23] = 1'b1; step(4);
        rd(5, v); check("R5 group2 flag", v, 5);
        wr(5, 8'h07);
        rd(5, v); check("R3 group flag clear", v, 0);

        // R6 / R8 / R9: ext0 edge flag and group1 flag both pending
        wr(1, 8'b0011);
        ext_pin[0] = 1'b1; step(4);
        wr(7, 8'h04);
        pc_pin[10] = 1'b1; step(4);
        rd(3, v); check("R2 ext0 rising flag", v & 1, 1);
        rd(5, v); check("R5 group1 flag", v, 2);
        wr(2, 0); wr(4, 0); wr(0, 1);
        retire_one(0);
        check("R6 flags without enables give no request", int'(irq_req), 0);
        wr(2, 1); wr(4, 3'b010);
        retire_one(0);
        check("R8 lowest vector wins", int'(irq_vec), vec_of(0));
        check("R7 request raised", int'(irq_req), 1);
        do_ack();
        rd(3, v); check("R9 ack clears accepted ext flag", v & 1, 0);
        rd(5, v); check("R9 other flag kept", v, 2);

        // R10 return-from-interrupt then one instruction
        retire_one(1);
        check("R10 no accept at return boundary", int'(irq_req), 0);
        rd(0, v); check("R10 return sets global enable", v, 1);
        retire_one(0);
        check("R10 accept after one instruction", int'(irq_req), 1);
        check("R8 group1 vector", int'(irq_vec), vec_of(NEXT + 1));
        do_ack();
        rd(5, v); check("R9 ack clears group flag", v, 0);
        wr(2, 0); wr(4, 0); wr(0, 0); wr(3, 3);

        // R5 random masks and toggles
        for (int it = 0; it < 40; it++) begin
            int g;
            logic [7:0] m, t;
            g = int'($urandom % NGRP);
            m = 8'($urandom);
            t = 8'($urandom);
            wr(6 + g, m);
            step(4);
            wr(5, 8'h07);
            pc_pin[g*GW +: GW] = pc_pin[g*GW +: GW] ^ t;
            step(4);
            rd(5, v);
            check("R5 random group flag", v, (|(m & t)) ? (1 << g) : 0);
        end

        // R8 random priority between groups
        for (int g = 0; g < NGRP; g++) wr(6 + g, 8'hFF);
        for (int it = 0; it < 20; it++) begin
            logic [2:0] fl, en;
            fl = 3'($urandom);
            en = 3'($urandom);
            if (fl == 0) fl = 3'b100;
            if ((fl & en) == 0) en = fl;
            step(4);
            wr(5, 8'h07);
            for (int g = 0; g < NGRP; g++)
                if (fl[g]) pc_pin[g*GW] = ~pc_pin[g*GW];
            step(4);
            wr(4, en);
            wr(0, 1);
            retire_one(0);
            check("R8 random winner request", int'(irq_req), 1);
            check("R8 random winner vector", int'(irq_vec), vec_of(NEXT + lowest_grp(fl & en)));
            do_ack();
            wr(0, 0);
        end

        finish_run();
    end
endmodule